// File: doc/BRIEF.md
# Single-Channel DMA Engine, Normal Transfer Mode

This block is one DMA channel that copies a programmed number of bytes, one data unit per transfer request, until the remaining byte count runs out. Each unit is a byte, a word or a longword, chosen at start-up. The channel is a bus master. It presents each bus cycle on a valid/ready request port and holds it there until the fabric accepts it.

The channel has two addressing schemes. In dual-address operation every unit is a read from the source address followed by a write of the same data to the destination address. In single-address operation one bus cycle is run at the memory address while the peripheral is strobed with the acknowledge output. Requests either come from an internal automatic source, which is dual-address only and always pending, or from an active-low external request level.

Software loads the configuration pins and pulses `cfg_start` while the channel is idle. The channel then runs by itself and stops with a sticky completion flag. A block-size configuration value is accepted but plays no part in this mode.

Top module: `dma_chan_normal`

## Requirements
- R1: Each serviced request moves exactly one unit whose size is `bus_size` = `cfg_size` latched at start (0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes). The remaining count drops by that many bytes per unit.
- R2: With `cfg_dual` = 1, each unit is a read beat (`bus_write` = 0) at the current source address. It is followed directly by a write beat (`bus_write` = 1) at the current destination address, carrying the data returned by the read.
- R3: With `cfg_dual` = 0, each unit is a single beat at the current source address with `bus_write` = `cfg_to_mem`. It is serviced only on external requests, whatever `cfg_auto` is.
- R4: External requests are taken while `dreq_n` is low in the cycle the channel waits for one. While `dreq_n` stays high, no beat is issued. A new request is considered only after the last beat of the current unit is accepted.
- R5: After each unit, the source and destination addresses each step according to their mode: 0 = fixed, 1 = increase by the unit size, 2 = decrease by the unit size. In single-address operation the destination is unused.
- R6: `dack_n` is low exactly while a beat of a serviced unit is on the bus, covering both beats of a dual-address unit. It is high between units.
- R7: `tend_n` is low only while the beats of the final unit of the programmed total are on the bus.
- R8: When the count is used up, `busy` falls in the cycle after the final beat is accepted and `done_flag` rises and stays set. A new start clears `done_flag`.
- R9: A `cfg_count` of 0 at start means 2^32 bytes.
- R10: `cfg_blk_size` has no effect on the beats, their number or the strobes.
- R11: Once `bus_valid` is high it stays high, with `bus_addr`, `bus_write`, `bus_size` and `bus_wdata` unchanged, until a cycle where `bus_ready` is high. Such a cycle completes the beat.
- R12: After reset, `busy`, `bus_valid` and `done_flag` are 0, and `dack_n` and `tend_n` are 1.
- R13: `cfg_start` while `busy` is 1 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_start | input | 1 | Start pulse, taken only while idle |
| cfg_dual | input | 1 | 1 = dual-address, 0 = single-address |
| cfg_auto | input | 1 | 1 = automatic requests (dual-address only) |
| cfg_to_mem | input | 1 | Single-address direction: 1 = write to memory |
| cfg_size | input | 2 | Unit size code |
| cfg_src_mode | input | 2 | Source address step mode |
| cfg_dst_mode | input | 2 | Destination address step mode |
| cfg_src | input | AW | Start source / memory address |
| cfg_dst | input | AW | Start destination address |
| cfg_count | input | 32 | Total bytes, 0 = 2^32 |
| cfg_blk_size | input | 16 | Block size, ignored in this mode |
| dreq_n | input | 1 | External transfer request, active low level |
| bus_valid | output | 1 | Beat request valid |
| bus_ready | input | 1 | Beat accepted / completed this cycle |
| bus_write | output | 1 | 1 = write beat |
| bus_addr | output | AW | Beat address |
| bus_size | output | 2 | Beat size code |
| bus_wdata | output | DW | Write data (dual-address) |
| bus_rdata | input | DW | Read data, valid when a read beat completes |
| dack_n | output | 1 | Transfer acknowledge, active low |
| tend_n | output | 1 | Final-transfer strobe, active low |
| busy | output | 1 | Channel enabled |
| done_flag | output | 1 | Sticky transfer-end flag |

## Verification
The assertions check several properties on every cycle: the hold rule of the request port, that acknowledge covers every beat, that the end strobe never appears without acknowledge, that a read beat in dual mode is always followed by a write beat, that the remaining count never grows between loads, and that the channel never drops out of busy without the completion flag. Other behaviour shows only in the bench's scenarios. These are the address sequences under each step mode, the data carried from read to write, which unit gets the end strobe, the zero-means-maximum count, the silence while the request level stays high, and the absence of effect from the block-size value and from a start while busy.

// File: rtl/dmac_pkg.sv
package dmac_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_WORD = 2'd1,
    SZ_LONG = 2'd2
  } unit_size_e;

  typedef enum logic [1:0] {
    AM_FIXED = 2'd0,
    AM_INC   = 2'd1,
    AM_DEC   = 2'd2
  } addr_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WAIT,
    ST_READ,
    ST_XFER
  } chan_state_e;

  function automatic logic [2:0] unit_bytes(input logic [1:0] sz);
    case (sz)
      SZ_BYTE: unit_bytes = 3'd1;
      SZ_WORD: unit_bytes = 3'd2;
      default: unit_bytes = 3'd4;
    endcase
  endfunction
endpackage

// File: rtl/dmac_addr_step.sv
module dmac_addr_step #(
  parameter int AW = 32
) (
  input  logic [AW-1:0] cur,
  input  logic [1:0]    mode,
  input  logic [2:0]    bytes,
  output logic [AW-1:0] nxt
);
  import dmac_pkg::*;

  always_comb begin
    case (mode)
      AM_INC:  nxt = cur + AW'(bytes);
      AM_DEC:  nxt = cur - AW'(bytes);
      default: nxt = cur;
    endcase
  end
endmodule

// File: rtl/dmac_count_unit.sv
module dmac_count_unit #(
  parameter int CW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  input  logic          dec,
  input  logic [2:0]    bytes,
  output logic          last
);
  localparam int RW = CW + 1;
  localparam logic [RW-1:0] FULL = RW'(1) << CW;

  logic [RW-1:0] rem;
  logic [RW-1:0] step;

  assign step = RW'(bytes);
  assign last = (rem <= step);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem <= '0;
    end else if (load) begin
      rem <= (load_val == '0) ? FULL : RW'(load_val);
    end else if (dec) begin
      rem <= (rem > step) ? rem - step : '0;
    end
  end

  // R1: between loads the remaining count only shrinks
  a_r1_no_grow: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> rem <= $past(rem));
endmodule

// File: rtl/dma_chan_normal.sv
module dma_chan_normal #(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int CW = 32,
  parameter int BW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_start,
  input  logic          cfg_dual,
  input  logic          cfg_auto,
  input  logic          cfg_to_mem,
  input  logic [1:0]    cfg_size,
  input  logic [1:0]    cfg_src_mode,
  input  logic [1:0]    cfg_dst_mode,
  input  logic [AW-1:0] cfg_src,
  input  logic [AW-1:0] cfg_dst,
  input  logic [CW-1:0] cfg_count,
  input  logic [BW-1:0] cfg_blk_size,
  input  logic          dreq_n,
  output logic          bus_valid,
  input  logic          bus_ready,
  output logic          bus_write,
  output logic [AW-1:0] bus_addr,
  output logic [1:0]    bus_size,
  output logic [DW-1:0] bus_wdata,
  input  logic [DW-1:0] bus_rdata,
  output logic          dack_n,
  output logic          tend_n,
  output logic          busy,
  output logic          done_flag
);
  import dmac_pkg::*;

  chan_state_e   st;
  logic          dual_q, auto_q, tomem_q;
  logic [1:0]    size_q, smode_q, dmode_q;
  logic [AW-1:0] src_q, dst_q, src_nxt, dst_nxt;
  logic [DW-1:0] data_q;
  logic [2:0]    bytes;
  logic          last, req_hit, load, unit_done;
  logic          blk_size_unused;

  assign blk_size_unused = ^cfg_blk_size;
  assign bytes     = unit_bytes(size_q);
  assign req_hit   = (dual_q && auto_q) ? 1'b1 : !dreq_n;
  assign load      = (st == ST_IDLE) && cfg_start;
  assign unit_done = (st == ST_XFER) && bus_ready;

  dmac_addr_step #(.AW(AW)) u_src_step (
    .cur(src_q), .mode(smode_q), .bytes(bytes), .nxt(src_nxt));
  dmac_addr_step #(.AW(AW)) u_dst_step (
    .cur(dst_q), .mode(dmode_q), .bytes(bytes), .nxt(dst_nxt));

  dmac_count_unit #(.CW(CW)) u_count (
    .clk(clk), .rst_n(rst_n), .load(load), .load_val(cfg_count),
    .dec(unit_done), .bytes(bytes), .last(last));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      dual_q    <= 1'b0;
      auto_q    <= 1'b0;
      tomem_q   <= 1'b0;
      size_q    <= '0;
      smode_q   <= '0;
      dmode_q   <= '0;
      src_q     <= '0;
      dst_q     <= '0;
      data_q    <= '0;
      dack_n    <= 1'b1;
      tend_n    <= 1'b1;
      done_flag <= 1'b0;
    end else begin
      case (st)
        ST_IDLE: if (cfg_start) begin
          dual_q    <= cfg_dual;
          auto_q    <= cfg_auto;
          tomem_q   <= cfg_to_mem;
          size_q    <= cfg_size;
          smode_q   <= cfg_src_mode;
          dmode_q   <= cfg_dst_mode;
          src_q     <= cfg_src;
          dst_q     <= cfg_dst;
          done_flag <= 1'b0;
          st        <= ST_WAIT;
        end
        ST_WAIT: if (req_hit) begin
          dack_n <= 1'b0;
          tend_n <= !last;
          st     <= dual_q ? ST_READ : ST_XFER;
        end
        ST_READ: if (bus_ready) begin
          data_q <= bus_rdata;
          st     <= ST_XFER;
        end
        ST_XFER: if (bus_ready) begin
          src_q  <= src_nxt;
          if (dual_q) dst_q <= dst_nxt;
          dack_n <= 1'b1;
          tend_n <= 1'b1;
          if (last) begin
            done_flag <= 1'b1;
            st        <= ST_IDLE;
          end else begin
            st <= ST_WAIT;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign busy      = (st != ST_IDLE);
  assign bus_valid = (st == ST_READ) || (st == ST_XFER);
  assign bus_write = (st == ST_XFER) && (dual_q || tomem_q);
  assign bus_addr  = ((st == ST_XFER) && dual_q) ? dst_q : src_q;
  assign bus_size  = size_q;
  assign bus_wdata = data_q;

  a_r11_hold_beat: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && !bus_ready |=> bus_valid && $stable(bus_addr) &&
      $stable(bus_write) && $stable(bus_size) && $stable(bus_wdata));

  a_r6_dack_covers_beat: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid |-> !dack_n);

  a_r7_tend_within_dack: assert property (@(posedge clk) disable iff (!rst_n)
    !tend_n |-> !dack_n);

  a_r2_read_then_write: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && bus_ready && !bus_write && dual_q |=> bus_valid && bus_write);

  a_r8_end_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done_flag);
endmodule

// File: tb/dma_chan_normal_test.sv
`timescale 1ns/1ps
module dma_chan_normal_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_start = 1'b0, cfg_dual = 1'b0, cfg_auto = 1'b0, cfg_to_mem = 1'b0;
  logic [1:0]  cfg_size = '0, cfg_src_mode = '0, cfg_dst_mode = '0;
  logic [31:0] cfg_src = '0, cfg_dst = '0, cfg_count = '0;
  logic [15:0] cfg_blk_size = '0;
  logic        dreq_n = 1'b1;
  logic        bus_valid, bus_ready = 1'b0, bus_write;
  logic [31:0] bus_addr, bus_wdata, bus_rdata;
  logic [1:0]  bus_size;
  logic        dack_n, tend_n, busy, done_flag;

  int n_cmp = 0;
  int n_bad = 0;
  bit wd_hit = 1'b0;

  always #2.5 clk = ~clk;

  function automatic logic [31:0] rd_fn(input logic [31:0] a);
    return (a * 32'h9E3779B1) ^ 32'h0F0F1234;
  endfunction

  function automatic logic [31:0] addr_at(input logic [31:0] base, input logic [1:0] m,
                                          input longint k, input int b);
    logic [31:0] off;
    off = 32'(k * b);
    if (m == 2'd1) return base + off;
    if (m == 2'd2) return base - off;
    return base;
  endfunction

  assign bus_rdata = rd_fn(bus_addr);

  dma_chan_normal uut (
    .clk(clk), .rst_n(rst_n), .cfg_start(cfg_start), .cfg_dual(cfg_dual),
    .cfg_auto(cfg_auto), .cfg_to_mem(cfg_to_mem), .cfg_size(cfg_size),
    .cfg_src_mode(cfg_src_mode), .cfg_dst_mode(cfg_dst_mode), .cfg_src(cfg_src),
    .cfg_dst(cfg_dst), .cfg_count(cfg_count), .cfg_blk_size(cfg_blk_size),
    .dreq_n(dreq_n), .bus_valid(bus_valid), .bus_ready(bus_ready),
    .bus_write(bus_write), .bus_addr(bus_addr), .bus_size(bus_size),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .dack_n(dack_n),
    .tend_n(tend_n), .busy(busy), .done_flag(done_flag));

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Runs one programmed transfer; stop_after limits how many units are requested.
  task automatic run_case(input bit dual, input bit auto_r, input bit tomem,
                          input logic [1:0] sz, input logic [1:0] sm, input logic [1:0] dm,
                          input logic [31:0] src, input logic [31:0] dst,
                          input logic [31:0] cnt, input logic [15:0] blk,
                          input longint stop_after, output longint units);
    int     b;
    longint n, k;
    bit     ph, ext;
    int     guard;
    b   = (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
    n   = (cnt == 0) ? ((64'd1 << 32) / b) : longint'(cnt / b);
    ext = !(dual && auto_r);
    k = 0; ph = 1'b0; guard = 0;
    @(negedge clk);
    cfg_dual = dual; cfg_auto = auto_r; cfg_to_mem = tomem; cfg_size = sz;
    cfg_src_mode = sm; cfg_dst_mode = dm; cfg_src = src; cfg_dst = dst;
    cfg_count = cnt; cfg_blk_size = blk; dreq_n = 1'b1; bus_ready = 1'b0;
    cfg_start = 1'b1;
    @(negedge clk);
    cfg_start = 1'b0;
    chk(busy == 1'b1 && done_flag == 1'b0, "R8 start", {busy, done_flag}, 2'b10);
    if (ext) begin
      for (int i = 0; i < 4; i++) begin
        @(negedge clk);
        chk(bus_valid == 1'b0, "R4 no beat while dreq_n high", bus_valid, 0);
      end
    end
    while (k < n && k < stop_after && guard < 5000) begin
      bus_ready = ($urandom % 3) != 0;
      if (ext) dreq_n = ($urandom % 4) == 0;
      if (bus_valid) begin
        chk(dack_n == 1'b0, "R6 dack during beat", dack_n, 0);
        chk(tend_n == !(k == n - 1), "R7 tend on final unit", tend_n, !(k == n - 1));
        if (bus_ready) begin
          chk(bus_size == sz, "R1 unit size", bus_size, sz);
          if (dual) begin
            chk(bus_write == ph, "R2 read then write", bus_write, ph);
            if (!ph)
              chk(bus_addr == addr_at(src, sm, k, b), "R5 source address", bus_addr, addr_at(src, sm, k, b));
            else begin
              chk(bus_addr == addr_at(dst, dm, k, b), "R5 destination address", bus_addr, addr_at(dst, dm, k, b));
              chk(bus_wdata == rd_fn(addr_at(src, sm, k, b)), "R2 write data", bus_wdata, rd_fn(addr_at(src, sm, k, b)));
            end
          end else begin
            chk(bus_write == tomem, "R3 single direction", bus_write, tomem);
            chk(bus_addr == addr_at(src, sm, k, b), "R3 single address", bus_addr, addr_at(src, sm, k, b));
          end
          if (!dual || ph) begin
            k++;
            ph = 1'b0;
            if (k >= stop_after) dreq_n = 1'b1;
          end else begin
            ph = 1'b1;
          end
        end
      end else begin
        chk(dack_n == 1'b1, "R6 dack idle between units", dack_n, 1);
      end
      @(negedge clk);
      guard++;
    end
    chk(guard < 5000, "R4 progress", guard, 5000);
    bus_ready = 1'b0;
    if (stop_after >= n) begin
      chk(busy == 1'b0 && done_flag == 1'b1, "R8 end state", {busy, done_flag}, 2'b01);
      chk(tend_n == 1'b1 && dack_n == 1'b1 && bus_valid == 1'b0, "R7 strobes released",
          {tend_n, dack_n, bus_valid}, 3'b110);
    end else begin
      repeat (5) @(negedge clk);
      chk(busy == 1'b1 && bus_valid == 1'b0 && done_flag == 1'b0, "R4 waits for request",
          {busy, bus_valid, done_flag}, 3'b100);
    end
    units = k;
  endtask

  initial begin
    longint u1, u2;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk(busy == 0 && bus_valid == 0 && done_flag == 0 && dack_n == 1 && tend_n == 1,
        "R12 reset state", {busy, bus_valid, done_flag, dack_n, tend_n}, 5'b00011);
    rst_n = 1'b1;

    // Directed: dual auto, bytes, both increment, single unit count
    run_case(1, 1, 0, 2'd0, 2'd1, 2'd1, 32'h1000, 32'h2000, 32'd1, 16'd0, 64'd100, u1);
    run_case(1, 1, 0, 2'd0, 2'd1, 2'd1, 32'h1000, 32'h2000, 32'd5, 16'd0, 64'd100, u1);
    // Dual driven by external request, longwords, decrement / fixed
    run_case(1, 0, 0, 2'd2, 2'd2, 2'd0, 32'h8000_0010, 32'h40, 32'd12, 16'd7, 64'd100, u1);
    // Single-address, words, to memory; auto bit set but ignored
    run_case(0, 1, 1, 2'd1, 2'd1, 2'd0, 32'h300, 32'h0, 32'd8, 16'd0, 64'd100, u1);
    run_case(0, 0, 0, 2'd2, 2'd2, 2'd1, 32'h10, 32'h0, 32'd16, 16'd0, 64'd100, u1);

    // R10: block size value changes nothing
    run_case(1, 1, 0, 2'd1, 2'd1, 2'd2, 32'h500, 32'h900, 32'd10, 16'd1, 64'd100, u1);
    run_case(1, 1, 0, 2'd1, 2'd1, 2'd2, 32'h500, 32'h900, 32'd10, 16'hFFFF, 64'd100, u2);
    chk(u1 == u2 && u1 == 5, "R10 block size ignored", u2, 5);

    // R9: zero count means 2^32 bytes, so after 3 units it is still running
    run_case(0, 0, 1, 2'd2, 2'd1, 2'd0, 32'hFFFF_FFF8, 32'h0, 32'd0, 16'd0, 64'd3, u1);
    chk(u1 == 3 && busy == 1'b1, "R9 zero count is maximum", busy, 1);
    // R13: start while busy is ignored (an auto dual restart would issue beats)
    @(negedge clk);
    cfg_dual = 1'b1; cfg_auto = 1'b1; cfg_start = 1'b1;
    @(negedge clk);
    cfg_start = 1'b0;
    bus_ready = 1'b1;
    repeat (5) begin
      @(negedge clk);
      chk(bus_valid == 1'b0 && busy == 1'b1, "R13 start while busy", bus_valid, 0);
    end
    bus_ready = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    chk(busy == 1'b0 && done_flag == 1'b0, "R12 reset after run", {busy, done_flag}, 0);

    // Constrained random mix
    for (int t = 0; t < 24; t++) begin
      logic [1:0] sz;
      logic [31:0] cnt;
      sz  = 2'($urandom % 3);
      cnt = 32'((1 + ($urandom % 6)) * ((sz == 0) ? 1 : (sz == 1) ? 2 : 4));
      run_case(1'($urandom % 2), 1'($urandom % 2), 1'($urandom % 2), sz,
               2'($urandom % 3), 2'($urandom % 3), $urandom, $urandom, cnt,
               16'($urandom), 64'd100, u1);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++;
    n_bad++;
    wd_hit = 1'b1;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule